// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter for One-Bit Streams

This block turns a one-bit density stream, from an on-chip delta-sigma modulator or from any other digital source, into multi-bit samples. Three integrators run in cascade. The first adds the incoming bit. The second adds the first integrator, and the third adds the second. All of them use wrap-around arithmetic of one fixed width, and that wrap cancels out once the values are differenced.

In free-running mode, the output register is a one-cycle-late copy of the third integrator. The host reads it at a steady interval of its own choosing and forms the three differences itself. For short, fast conversions the block can instead run its own comb. A decimation counter counts the input samples. Each time a programmed count is reached, the comb latches the third integrator and forms three successive differences; there is no fourth. The third difference goes to the output with a one-cycle strobe and a sticky valid flag. The integrators advance either on every system clock or only on rising edges of a separate bitstream clock pin. The second choice lets an external modulator with its own link clock drive the filter.

Top module: `sinc3_filter`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `sample_q` is 0, and `result_strobe`, `result_valid` and `settling` are low.
- R2: With `ext_clk_mode`=0 and `comb_en`=0, the integrators advance on every clock. Using their previous values, i1+=bit_in, i2+=i1 and i3+=i2, and `sample_q` equals i3 as it stood one cycle earlier.
- R3: With `ext_clk_mode`=1, the integrators advance once per rising edge of `bclk_in`. That edge is seen through a two-flop synchronizer, and `bit_in` is sampled on the detect cycle. Falling edges, and stretches with no edge, leave the integrators unchanged.
- R4: With `comb_en`=1, a result is produced after every `dec_len` advances, with `dec_len` values of 0 and 1 both meaning every advance. The result is the third difference of the latched i3, with zero history after a clear. It appears on `sample_q` on the same cycle that `result_strobe` pulses.
- R5: `result_valid` rises with `result_strobe` and stays high until `rd_ack` is seen on a cycle with no new result.
- R6: The first two results after a clear carry `settling`=1, and later results carry `settling`=0.
- R7: A change of `ext_clk_mode` or `comb_en` clears the integrators, comb history, decimation counter and output state, exactly as reset does.
- R8: In comb mode, a periodic input whose period divides `dec_len` settles to dec_len³ × density. With `dec_len`=8, all ones gives 512, alternating bits give 256 and all zeros give 0. Before settling, all ones gives 56 and then 392.
- R9: In comb mode, `sample_q` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | One-bit density stream |
| bclk_in | input | 1 | External bitstream clock pin |
| ext_clk_mode | input | 1 | 1: advance on rising edges of bclk_in; 0: every clock |
| comb_en | input | 1 | 1: hardware comb mode; 0: free-running integrator copy |
| dec_len | input | DEC_W | Advances per hardware result |
| rd_ack | input | 1 | Host acknowledges the current result |
| sample_q | output | ACC_W | Integrator copy or comb result |
| result_strobe | output | 1 | One-cycle pulse when a new comb result is loaded |
| result_valid | output | 1 | Sticky flag for an unacknowledged result |
| settling | output | 1 | Current result is one of the first two after a clear |

## Verification
Free-running mode is driven with a constant-one stream and an irregular pattern. The constant stream confirms the cubic growth of the cascade. The irregular pattern separates correct old-value chaining from stages that read already-updated neighbours. In external-clock mode, the bit changes between link-clock edges while the clock stays held for long stretches. This shows that exactly one sample is taken per rising edge and none on falling edges or idle time. The comb is driven with all-ones, alternating and all-zero streams, and with a decimation length of zero. These patterns tell a correct third difference apart from a wrong order, a missing stage or a wrong window length, and they also expose the settling results and the flag handshake.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned SETTLE_RESULTS = 2;
  localparam int unsigned SETTLE_W = 2;

  typedef enum logic {
    ADV_SYSCLK = 1'b0,
    ADV_LINKCLK = 1'b1
  } adv_src_e;
endpackage

// File: rtl/sinc3_edge_sync.sv
module sinc3_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], pin_in};
  end

  assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
endmodule

// File: rtl/sinc3_integ_chain.sv
module sinc3_integ_chain #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             adv,
  input  logic             bit_in,
  output logic [ACC_W-1:0] last_acc
);
  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] addend [STAGES];

  assign addend[0] = {{(ACC_W-1){1'b0}}, bit_in};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_feed
      assign addend[g] = acc_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (clr)      acc_q[g] <= '0;
      else if (adv) acc_q[g] <= acc_q[g] + addend[g];
    end
  end

  assign last_acc = acc_q[STAGES-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned DEC_W  = 16,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             adv,
  input  logic [DEC_W-1:0] dec_len,
  input  logic [ACC_W-1:0] integ_in,
  output logic             load,
  output logic [ACC_W-1:0] diff_out
);
  logic [DEC_W-1:0] cnt_q;
  logic             last;
  logic [ACC_W-1:0] hist_q [STAGES];
  logic [ACC_W-1:0] diff [STAGES];

  assign last = ({1'b0, cnt_q} + {{DEC_W{1'b0}}, 1'b1}) >= {1'b0, dec_len};

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      load  <= 1'b0;
    end else begin
      load <= adv & last;
      if (adv) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign diff[0] = integ_in - hist_q[0];

  for (genvar g = 0; g < STAGES; g++) begin : g_diff
    if (g > 0) begin : g_chain
      assign diff[g] = diff[g-1] - hist_q[g];
    end
    always_ff @(posedge clk) begin
      if (clr)       hist_q[g] <= '0;
      else if (load) hist_q[g] <= (g == 0) ? integ_in : diff[g-1];
    end
  end

  assign diff_out = diff[STAGES-1];
endmodule

// File: rtl/sinc3_filter.sv
module sinc3_filter
  import sinc3_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned DEC_W  = 16,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bclk_in,
  input  logic             ext_clk_mode,
  input  logic             comb_en,
  input  logic [DEC_W-1:0] dec_len,
  input  logic             rd_ack,
  output logic [ACC_W-1:0] sample_q,
  output logic             result_strobe,
  output logic             result_valid,
  output logic             settling
);
  logic [1:0]          mode_q;
  logic                clear;
  logic                link_rise;
  logic                adv;
  logic [ACC_W-1:0]    integ3;
  logic                res_load;
  logic [ACC_W-1:0]    res_diff;
  logic [SETTLE_W-1:0] nres_q;
  adv_src_e            src;

  assign src   = adv_src_e'(ext_clk_mode);
  assign clear = rst | ({ext_clk_mode, comb_en} != mode_q);
  assign adv   = (src == ADV_LINKCLK) ? link_rise : 1'b1;

  always_ff @(posedge clk) begin
    mode_q <= {ext_clk_mode, comb_en};
  end

  sinc3_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .pin_in(bclk_in), .rise(link_rise)
  );

  sinc3_integ_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .clr(clear), .adv(adv), .bit_in(bit_in), .last_acc(integ3)
  );

  sinc3_comb #(.ACC_W(ACC_W), .DEC_W(DEC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .clr(clear), .adv(adv & comb_en), .dec_len(dec_len),
    .integ_in(integ3), .load(res_load), .diff_out(res_diff)
  );

  always_ff @(posedge clk) begin
    if (clear) begin
      sample_q      <= '0;
      result_strobe <= 1'b0;
      result_valid  <= 1'b0;
      settling      <= 1'b0;
      nres_q        <= '0;
    end else begin
      result_strobe <= 1'b0;
      if (comb_en) begin
        if (res_load) begin
          sample_q      <= res_diff;
          result_strobe <= 1'b1;
          result_valid  <= 1'b1;
          settling      <= (nres_q < SETTLE_W'(SETTLE_RESULTS));
          if (nres_q < SETTLE_W'(SETTLE_RESULTS)) nres_q <= nres_q + 1'b1;
        end else if (rd_ack) begin
          result_valid <= 1'b0;
        end
      end else begin
        sample_q <= integ3;
      end
    end
  end
endmodule

// File: rtl/sinc3_checker.sv
module sinc3_checker #(
  parameter int unsigned ACC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             ext_clk_mode,
  input logic             comb_en,
  input logic             link_rise,
  input logic [ACC_W-1:0] integ3,
  input logic [ACC_W-1:0] sample_q,
  input logic             result_strobe,
  input logic             result_valid,
  input logic             rd_ack
);
  assert_copy_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear) && !$past(comb_en)) |-> sample_q == $past(integ3));

  assert_link_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ext_clk_mode && !link_rise && !clear) |=> $stable(integ3));

  assert_strobe_valid_R4: assert property (@(posedge clk) disable iff (rst)
    result_strobe |-> result_valid);

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !rd_ack && !clear) |=> result_valid);

  assert_clear_state_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (integ3 == '0 && !result_valid && !result_strobe && sample_q == '0));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    (comb_en && !clear && $past(comb_en) && !result_strobe && !$past(clear)) |-> $stable(sample_q));
endmodule

bind sinc3_filter sinc3_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .ext_clk_mode(ext_clk_mode),
  .comb_en(comb_en), .link_rise(link_rise), .integ3(integ3),
  .sample_q(sample_q), .result_strobe(result_strobe),
  .result_valid(result_valid), .rd_ack(rd_ack)
);

// File: tb/test_sinc3_filter.sv
module test_sinc3_filter;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 32;
  localparam int DEC_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bclk_in = 1'b0;
  logic ext_clk_mode = 1'b0;
  logic comb_en = 1'b0;
  logic [DEC_W-1:0] dec_len = 16'd8;
  logic rd_ack = 1'b0;
  logic [ACC_W-1:0] sample_q;
  logic result_strobe, result_valid, settling;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc3_filter #(.ACC_W(ACC_W), .DEC_W(DEC_W), .STAGES(3)) i_sinc3_filter (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bclk_in(bclk_in),
    .ext_clk_mode(ext_clk_mode), .comb_en(comb_en), .dec_len(dec_len),
    .rd_ack(rd_ack), .sample_q(sample_q), .result_strobe(result_strobe),
    .result_valid(result_valid), .settling(settling)
  );

  task automatic check(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    ext_clk_mode = 1'b0; comb_en = 1'b0; bit_in = 1'b1;
    do_reset();
    check("R1 sample", sample_q, 0);
    check("R1 strobe", {31'd0, result_strobe}, 0);
    check("R1 valid", {31'd0, result_valid}, 0);
    check("R1 settling", {31'd0, settling}, 0);
  endtask

  // R2: free-running cascade, cycle exact
  task automatic t_free(input int pat);
    logic [ACC_W-1:0] m1, m2, m3, old3;
    ext_clk_mode = 1'b0; comb_en = 1'b0;
    do_reset();
    m1 = 0; m2 = 0; m3 = 0;
    for (int k = 0; k < 14; k++) begin
      bit_in = (pat == 0) ? 1'b1 : (((k * 5) % 3) == 0);
      @(posedge clk);
      old3 = m3;
      m3 = m3 + m2; m2 = m2 + m1; m1 = m1 + {31'd0, bit_in};
      @(negedge clk);
      check("R2 integrator copy", sample_q, old3);
    end
  endtask

  // R3: external link clock
  task automatic t_ext();
    logic [ACC_W-1:0] m1, m2, m3;
    logic [5:0] bits;
    bits = 6'b101011;
    ext_clk_mode = 1'b0; comb_en = 1'b0;
    do_reset();
    @(negedge clk); ext_clk_mode = 1'b1; bclk_in = 1'b0;
    m1 = 0; m2 = 0; m3 = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      bit_in = bits[k];
      repeat (5) @(negedge clk);
      bclk_in = 1'b1;
      repeat (5) @(negedge clk);
      bit_in = ~bits[k];
      bclk_in = 1'b0;
      m3 = m3 + m2; m2 = m2 + m1; m1 = m1 + {31'd0, bits[k]};
    end
    repeat (6) @(negedge clk);
    check("R3 one sample per rising edge", sample_q, m3);
    bit_in = 1'b1;
    repeat (20) @(negedge clk);
    check("R3 idle link clock holds", sample_q, m3);
  endtask

  // R4 R5 R6 R8 R9: hardware comb
  task automatic t_comb(input int pat, input int dlen, input int nres,
                        output logic [ACC_W-1:0] res [8], output logic [7:0] stl);
    int got, cyc;
    logic [ACC_W-1:0] held;
    logic ok_hold;
    ext_clk_mode = 1'b0; comb_en = 1'b0;
    do_reset();
    dec_len = DEC_W'(dlen);
    @(negedge clk); comb_en = 1'b1;
    got = 0; cyc = 0; held = 0; ok_hold = 1'b1; stl = 0;
    while (got < nres && cyc < 400) begin
      bit_in = (pat == 0) ? 1'b1 : (pat == 1) ? cyc[0] : 1'b0;
      @(negedge clk);
      cyc++;
      if (result_strobe) begin
        res[got] = sample_q; stl[got] = settling; held = sample_q; got++;
      end else if (got > 0 && sample_q !== held) ok_hold = 1'b0;
    end
    check("R4 result count", got, nres);
    check("R9 holds between strobes", {31'd0, ok_hold}, 1);
    check("R5 valid stays without ack", {31'd0, result_valid}, 1);
  endtask

  task automatic t_comb_all();
    logic [ACC_W-1:0] r [8];
    logic [7:0] s;
    t_comb(0, 8, 4, r, s);
    check("R8 ones first", r[0], 56);
    check("R8 ones second", r[1], 392);
    check("R8 ones settled", r[2], 512);
    check("R8 ones settled again", r[3], 512);
    check("R6 settling first two", {30'd0, s[1:0]}, 3);
    check("R6 settled later", {30'd0, s[3:2]}, 0);
    t_comb(1, 8, 4, r, s);
    check("R8 alternating", r[2], 256);
    check("R8 alternating again", r[3], 256);
    t_comb(2, 8, 3, r, s);
    check("R8 zeros", r[2], 0);
    t_comb(0, 0, 7, r, s);
    check("R4 dec_len zero every sample", r[6], 1);
  endtask

  // R5: acknowledge handshake
  task automatic t_ack();
    int cyc;
    ext_clk_mode = 1'b0; comb_en = 1'b0; bit_in = 1'b1;
    do_reset();
    dec_len = 16'd8;
    @(negedge clk); comb_en = 1'b1;
    cyc = 0;
    while (!result_strobe && cyc < 50) begin @(negedge clk); cyc++; end
    rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    check("R5 ack clears valid", {31'd0, result_valid}, 0);
    repeat (3) @(negedge clk);
    check("R5 stays clear", {31'd0, result_valid}, 0);
    cyc = 0;
    while (!result_strobe && cyc < 50) begin @(negedge clk); cyc++; end
    check("R5 new result sets valid", {31'd0, result_valid}, 1);
  endtask

  // R7: mode change clears
  task automatic t_mode();
    int cyc;
    ext_clk_mode = 1'b0; comb_en = 1'b0; bit_in = 1'b1;
    do_reset();
    dec_len = 16'd8;
    @(negedge clk); comb_en = 1'b1;
    cyc = 0;
    while (!result_strobe && cyc < 50) begin @(negedge clk); cyc++; end
    repeat (20) @(negedge clk);
    comb_en = 1'b0;
    @(negedge clk);
    check("R7 clear output", sample_q, 0);
    check("R7 clear valid", {31'd0, result_valid}, 0);
    comb_en = 1'b1;
    cyc = 0;
    while (!result_strobe && cyc < 50) begin @(negedge clk); cyc++; end
    check("R7 restart first result", sample_q, 56);
    check("R7 restart settling", {31'd0, settling}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_free(0);
    t_free(1);
    t_ext();
    t_comb_all();
    t_ack();
    t_mode();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule